// File: doc/BRIEF.md
# Registered Three-Value Signed Sorter

This block captures three 4-bit two's complement operands (range -8 to +7) into an input register bank and orders them with signed compare logic. The resulting maximum, middle and minimum values are then captured into an output register bank with three slots: Top, Mid and Bottom.

The two banks load separately. `start` enables the input bank and `finish` enables the output bank. A `mode` bit chooses ascending placement (Top holds the maximum) or descending placement (Top holds the minimum). The middle value always goes to Mid. Display decoding, debouncing and the sequencing that produces `start` and `finish` belong to the surrounding logic.

Top module: `sorter3_top`

## Requirements
- R1: `rst` is active high and asynchronous. While it is high, all six registers (`regA`, `regB`, `regC`, `outTop`, `outMid`, `outBot`) read 4'b0000, without waiting for a clock edge.
- R2: With `rst` low and `start` at 1, each rising `clk` edge loads `inA`, `inB` and `inC` into `regA`, `regB` and `regC`.
- R3: With `rst` low and `start` at 0, `regA`, `regB` and `regC` keep their values whatever the switch inputs do.
- R4: With `rst` low and `finish` at 1, each rising `clk` edge loads the sorted form of the input register contents present just before that edge into `outTop`, `outMid` and `outBot`.
- R5: With `rst` low and `finish` at 0, `outTop`, `outMid` and `outBot` keep their values.
- R6: When `mode` is 0 (ascending) at the loading edge, `outTop` receives the signed maximum and `outBot` the signed minimum. Bit 3 is the sign bit, so 4'b1000 (-8) is below 4'b0111 (+7).
- R7: When `mode` is 1 (descending) at the loading edge, `outTop` receives the signed minimum and `outBot` the signed maximum.
- R8: `outMid` receives the signed middle value in either mode.
- R9: Equal operands still sort correctly, with duplicates placed next to each other. For example, -3, -3, 5 in mode 0 gives Top 5, Mid -3, Bottom -3.
- R10: `mode` only matters at an edge where `finish` is 1. Changing it later does not change `outTop`, `outMid` or `outBot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high clear of all registers |
| start | input | 1 | Load enable for the input bank |
| finish | input | 1 | Load enable for the output bank |
| mode | input | 1 | 0 = ascending (Top is max), 1 = descending (Top is min) |
| inA | input | 4 | Operand A switches, two's complement |
| inB | input | 4 | Operand B switches, two's complement |
| inC | input | 4 | Operand C switches, two's complement |
| regA | output | 4 | Registered operand A |
| regB | output | 4 | Registered operand B |
| regC | output | 4 | Registered operand C |
| outTop | output | 4 | Top slot: max or min depending on mode |
| outMid | output | 4 | Middle value |
| outBot | output | 4 | Bottom slot: min or max depending on mode |

## Verification
The assertions check every cycle that:
- each bank holds when its enable is low and loads when its enable is high;
- the Mid slot takes the sort network's middle value;
- the output bank is ordered correctly (descending Top to Bottom after an ascending load, and the reverse after a descending load).

Several things only the bench's scenarios can show:
- that the values are the correct signed maximum, middle and minimum of the operands, including duplicates and the -8/+7 extremes;
- that reset clears the registers asynchronously between clock edges;
- that toggling `mode` after a load leaves the output bank untouched.

// File: rtl/sorter3_pkg.sv
`timescale 1ns/1ps
package sorter3_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic loadIn;   // capture switch operands
    logic loadOut;  // capture sorted results
    logic descend;  // swap extremes between Top and Bottom
  } strobe_t;
endpackage

// File: rtl/sort3_net.sv
`timescale 1ns/1ps
module sort3_net #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] maxV,
  output logic [W-1:0] midV,
  output logic [W-1:0] minV
);
  logic aGeB, aGeC, bGeC;

  always_comb begin
    aGeB = $signed(a) >= $signed(b);
    aGeC = $signed(a) >= $signed(c);
    bGeC = $signed(b) >= $signed(c);

    if (aGeB && aGeC)        maxV = a;
    else if (!aGeB && bGeC)  maxV = b;
    else                     maxV = c;

    // minimum selection reuses the same three flags (a <= b is !aGeB or equal)
    if ((!aGeB || a == b) && (!aGeC || a == c)) minV = a;
    else if (aGeB && (!bGeC || b == c))         minV = b;
    else                                        minV = c;

    // middle by modular subtraction; exact since the result fits W bits
    midV = a + b + c - maxV - minV;
  end
endmodule

// File: rtl/sorter3_ctrl.sv
`timescale 1ns/1ps
module sorter3_ctrl
  import sorter3_pkg::*;
(
  input  logic    start,
  input  logic    finish,
  input  logic    mode,
  output strobe_t strobe
);
  always_comb begin
    strobe.loadIn  = start;
    strobe.loadOut = finish;
    strobe.descend = mode;
  end
endmodule

// File: rtl/sorter3_dp.sv
`timescale 1ns/1ps
module sorter3_dp
  import sorter3_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  strobe_t      strobe,
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  output logic [W-1:0] regA,
  output logic [W-1:0] regB,
  output logic [W-1:0] regC,
  output logic [W-1:0] outTop,
  output logic [W-1:0] outMid,
  output logic [W-1:0] outBot
);
  logic [W-1:0] maxV, midV, minV;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
      regC <= '0;
    end else if (strobe.loadIn) begin
      regA <= inA;
      regB <= inB;
      regC <= inC;
    end
  end

  sort3_net #(.W(W)) net (
    .a(regA), .b(regB), .c(regC),
    .maxV(maxV), .midV(midV), .minV(minV)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      outTop <= '0;
      outMid <= '0;
      outBot <= '0;
    end else if (strobe.loadOut) begin
      outTop <= strobe.descend ? minV : maxV;
      outMid <= midV;
      outBot <= strobe.descend ? maxV : minV;
    end
  end

  // R2
  inLoad_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.loadIn |=> (regA == $past(inA) && regB == $past(inB) && regC == $past(inC)));

  // R3
  inHold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadIn |=> ($stable(regA) && $stable(regB) && $stable(regC)));

  // R5
  outHold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadOut |=> ($stable(outTop) && $stable(outMid) && $stable(outBot)));

  // R8
  midLoad_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.loadOut |=> outMid == $past(midV));

  // R6
  ascOrder_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadOut && !strobe.descend) |=>
      ($signed(outTop) >= $signed(outMid) && $signed(outMid) >= $signed(outBot)));

  // R7
  descOrder_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadOut && strobe.descend) |=>
      ($signed(outTop) <= $signed(outMid) && $signed(outMid) <= $signed(outBot)));
endmodule

// File: rtl/sorter3_top.sv
`timescale 1ns/1ps
module sorter3_top
  import sorter3_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         finish,
  input  logic         mode,
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  output logic [W-1:0] regA,
  output logic [W-1:0] regB,
  output logic [W-1:0] regC,
  output logic [W-1:0] outTop,
  output logic [W-1:0] outMid,
  output logic [W-1:0] outBot
);
  strobe_t strobe;

  sorter3_ctrl ctrl (
    .start(start), .finish(finish), .mode(mode), .strobe(strobe)
  );

  sorter3_dp #(.W(W)) dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .inA(inA), .inB(inB), .inC(inC),
    .regA(regA), .regB(regB), .regC(regC),
    .outTop(outTop), .outMid(outMid), .outBot(outBot)
  );
endmodule

// File: tb/tb_sorter3_top.sv
`timescale 1ns/1ps
module tb_sorter3_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, finish = 1'b0, mode = 1'b0;
  logic [3:0] inA = '0, inB = '0, inC = '0;
  logic [3:0] regA, regB, regC, outTop, outMid, outBot;

  int checks = 0;
  int errors = 0;
  logic pend = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic [3:0] top, mid, bot;
    string req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  sorter3_top dut (
    .clk(clk), .rst(rst), .start(start), .finish(finish), .mode(mode),
    .inA(inA), .inB(inB), .inC(inC),
    .regA(regA), .regB(regB), .regC(regC),
    .outTop(outTop), .outMid(outMid), .outBot(outBot)
  );

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference ordering, computed with integers
  function automatic item_t model(logic [3:0] a, logic [3:0] b, logic [3:0] c,
                                  logic m, string req);
    int v[3];
    int t;
    item_t it;
    v[0] = $signed(a); v[1] = $signed(b); v[2] = $signed(c);
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2 - i; j++)
        if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
    it.mid = 4'(v[1]);
    it.top = m ? 4'(v[0]) : 4'(v[2]);
    it.bot = m ? 4'(v[2]) : 4'(v[0]);
    it.req = req;
    return it;
  endfunction

  // monitor: finish seen at an edge -> compare at the next falling edge
  always @(posedge clk or posedge rst)
    if (rst) pend <= 1'b0; else pend <= finish;

  always @(negedge clk) begin
    if (pend) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 actual=unexpected load expected=none");
      end else begin
        item_t e;
        e = sb.pop_front();
        chk(e.req, {outTop, outMid, outBot}, {e.top, e.mid, e.bot});
      end
    end
  end

  // driver: load operands, then sort them into the output bank
  task automatic runSort(logic [3:0] a, logic [3:0] b, logic [3:0] c, logic m,
                         string req, bit chkIn);
    @(negedge clk);
    inA = a; inB = b; inC = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (chkIn) chk("R2", {regA, regB, regC}, {a, b, c});
    mode = m; finish = 1'b1;
    sb.push_back(model(a, b, c, m, req));
    @(negedge clk);
    finish = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] held;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", {regA, regB, regC}, 12'h000);
    chk("R1", {outTop, outMid, outBot}, 12'h000);
    rst = 1'b0;

    runSort(4'h7, 4'h8, 4'h0, 1'b0, "R6", 1'b1);   // +7, -8, 0 ascending
    runSort(4'h7, 4'h8, 4'h0, 1'b1, "R7", 1'b1);   // descending
    runSort(4'h2, 4'h9, 4'h5, 1'b1, "R8", 1'b1);
    runSort(4'hD, 4'hD, 4'h5, 1'b0, "R9", 1'b1);   // -3,-3,5
    runSort(4'h8, 4'h8, 4'h8, 1'b1, "R9", 1'b1);   // all -8
    @(negedge clk);

    // R3: switches change, start low -> input bank holds
    held = {regA, regB, regC};
    inA = 4'h1; inB = 4'h2; inC = 4'h3;
    repeat (3) @(negedge clk);
    chk("R3", {regA, regB, regC}, held);

    // R5 / R10: finish low, mode toggles and new operands load
    held = {outTop, outMid, outBot};
    mode = ~mode;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode = ~mode;
    repeat (2) @(negedge clk);
    chk("R5", {outTop, outMid, outBot}, held);
    chk("R10", {outTop, outMid, outBot}, held);
    chk("R2", {regA, regB, regC}, 12'h123);

    // R4: exhaustive sweep, mode alternating
    for (int k = 0; k < 4096; k++)
      runSort(k[11:8], k[7:4], k[3:0], k[0] ^ k[4] ^ k[8], "R4", 1'b0);
    @(negedge clk);
    chk("R4", 12'(sb.size()), 12'd0);

    // R1 asynchronous reset between edges
    #3 rst = 1'b1;
    #1;
    chk("R1", {regA, regB, regC}, 12'h000);
    chk("R1", {outTop, outMid, outBot}, 12'h000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule